// File: doc/BRIEF.md
# Dual-Clock FIFO With Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words that sits between two unrelated clock domains. The producer pushes words on its own clock and the consumer pulls them on another; each side is gated by a pair of active-low enables. Two fixed status outputs report a completely empty or completely full buffer. Two more outputs give early warning when the buffer is nearly drained or nearly filled, and their thresholds can be changed while the block is running.

The two thresholds live in a small offset store in the producer domain. The pin that normally acts as the second write enable can instead serve as a load strobe. Its role is chosen by its level while reset is held. In load mode, enabled write edges with the strobe low store the near-empty threshold and then the near-full threshold, taken from the low bits of the data input, instead of pushing data. Pointers cross between the domains in Gray code through two-flop synchronisers. Each flag is computed in the domain that acts on it, so the flags are conservative: a flag may stay asserted a few cycles longer than the true state, but never says there is room or data that is not there. An output-enable input becomes a drive qualifier beside the read data.

Top module: `dcfifo_pf`

## Requirements
- R1: In two-enable mode, a word on `din` is stored on a rising `wr_clk` edge only when `wen_n` and `wen2_ld_n` are both low and the buffer is not full. A low on only one of them stores nothing.
- R2: When `ren_n` and `ren2_n` are both low at a rising `rd_clk` edge and the buffer is not empty, the oldest word appears on `q` after that edge, in write order. A low on only one of them leaves `q` and the contents unchanged.
- R3: `full_n` is low when DEPTH words are held. A write attempted while `full_n` is low is dropped and the stored contents do not change.
- R4: `empty_n` is low when no word is available. A read attempted while `empty_n` is low leaves `q` unchanged and removes nothing.
- R5: `ae_n` is low exactly when the settled occupancy is at or below the near-empty offset. The offset is 7 after reset.
- R6: `af_n` is low exactly when the settled free space (DEPTH minus occupancy) is at or below the near-full offset. The offset is 7 after reset.
- R7: The level on `wen2_ld_n` while reset is applied and for two `wr_clk` edges after its release selects the mode. High selects two-enable mode; low selects load mode, where `wen2_ld_n` is the load strobe.
- R8: In load mode, with `wen_n` low, an edge with `wen2_ld_n` low stores `din[5:0]` (for DEPTH 64) as an offset and pushes no data. The first such edge sets the near-empty offset and the next one sets the near-full offset, and the order restarts once the strobe goes high. An edge with `wen_n` low and `wen2_ld_n` high pushes data.
- R9: After reset, `empty_n`=0, `full_n`=1, `ae_n`=0, `af_n`=1 and `q`=0.
- R10: `q_oe` equals the inverse of `oe_n` and has no effect on stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen_n | input | 1 | First write enable, active low |
| wen2_ld_n | input | 1 | Second write enable or load strobe, active low |
| din | input | 9 | Write data; low bits carry offsets in load mode |
| ren_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| q | output | 9 | Read data register |
| q_oe | output | 1 | Drive qualifier for `q` |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| ae_n | output | 1 | Near-empty flag, active low |
| af_n | output | 1 | Near-full flag, active low |

## Verification
The assertions assume that offsets are loaded only while the consumer side is idle, since the near-empty offset is read across domains without a handshake, and that `wen2_ld_n` is steady around reset release. The stimulus loads offsets only after a reset with no reads pending. It holds the mode pin for several cycles after release and changes every input at the falling edge of its own clock. Flag values are compared exactly only after both domains have idled long enough for the synchronisers to settle. During traffic, the bench checks only the safe direction: no read is granted on empty and no write on full.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int PTR_MAX = 11;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 9,
  parameter int AW     = 6,
  parameter int PW     = 7,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_rst_n,
  input  logic              wen_n,
  input  logic              shr_n,
  input  logic [DATA_W-1:0] din,
  input  logic [PW-1:0]     rgray_s,
  output logic              w_fire,
  output logic [AW-1:0]     waddr,
  output logic [PW-1:0]     wgray,
  output logic [OFF_W-1:0]  ae_off,
  output logic              full_n,
  output logic              af_n
);
  logic [PW-1:0]    wbin, wbin_nx, wgray_nx, rbin_s, used, free;
  logic [OFF_W-1:0] ae_nx, af_off, af_nx;
  logic             ld_mode, ld_idx, ld_idx_nx, w_req, ld_fire, full, afull;

  always_comb begin
    w_req    = ld_mode ? (!wen_n && shr_n) : (!wen_n && !shr_n);
    ld_fire  = ld_mode && !wen_n && !shr_n;
    rbin_s   = PW'(gray2bin(ptr_t'(rgray_s)));
    used     = wbin - rbin_s;
    free     = PW'(DEPTH) - used;
    full     = (used == PW'(DEPTH));
    afull    = (free <= PW'(af_off));
    w_fire   = w_req && !full;
    wbin_nx  = w_fire ? wbin + 1'b1 : wbin;
    wgray_nx = PW'(bin2gray(ptr_t'(wbin_nx)));
    ae_nx     = ae_off;
    af_nx     = af_off;
    ld_idx_nx = ld_idx;
    if (ld_fire) begin
      if (!ld_idx) ae_nx = din[OFF_W-1:0];
      else         af_nx = din[OFF_W-1:0];
      ld_idx_nx = !ld_idx;
    end else if (ld_mode && shr_n) begin
      ld_idx_nx = 1'b0;
    end
  end

  // pin role is sampled while the synchronised reset is still low
  always_ff @(posedge clk or negedge raw_rst_n) begin
    if (!raw_rst_n)  ld_mode <= 1'b0;
    else if (!rst_n) ld_mode <= !shr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      ae_off <= OFF_W'(7);
      af_off <= OFF_W'(7);
      ld_idx <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      ae_off <= ae_nx;
      af_off <= af_nx;
      ld_idx <= ld_idx_nx;
    end
  end

  assign waddr  = wbin[AW-1:0];
  assign full_n = !full;
  assign af_n   = !afull;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_req && !full_n) |=> $stable(wbin));
  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
  assert_full_is_near_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !af_n);
  assert_load_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> $stable(wbin));
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = 7,
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_n,
  input  logic             ren2_n,
  input  logic [PW-1:0]    wgray_s,
  input  logic [OFF_W-1:0] ae_off,
  output logic             r_fire,
  output logic [AW-1:0]    raddr,
  output logic [PW-1:0]    rgray,
  output logic             empty_n,
  output logic             ae_n
);
  logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, used;
  logic          r_req, empty, aempty;

  always_comb begin
    r_req    = !ren_n && !ren2_n;
    wbin_s   = PW'(gray2bin(ptr_t'(wgray_s)));
    used     = wbin_s - rbin;
    empty    = (used == '0);
    aempty   = (used <= PW'(ae_off));
    r_fire   = r_req && !empty;
    rbin_nx  = r_fire ? rbin + 1'b1 : rbin;
    rgray_nx = PW'(bin2gray(ptr_t'(rbin_nx)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
    end
  end

  assign raddr   = rbin[AW-1:0];
  assign empty_n = !empty;
  assign ae_n    = !aempty;

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_req && !empty_n) |=> $stable(rbin));
  assert_rd_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
  assert_empty_is_near_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !ae_n);
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 9,
  parameter int AW     = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  q <= '0;
    else if (re)  q <= cells[raddr];
  end
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 9
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wen_n,
  input  logic              wen2_ld_n,
  input  logic [DATA_W-1:0] din,
  input  logic              ren_n,
  input  logic              ren2_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q,
  output logic              q_oe,
  output logic              empty_n,
  output logic              full_n,
  output logic              ae_n,
  output logic              af_n
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int OFF_W = (AW < DATA_W) ? AW : DATA_W;

  logic             wr_rst_n, rd_rst_n, w_fire, r_fire;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
  logic [OFF_W-1:0] ae_off;

  dcfifo_sync #(.W(1)) u_wr_rst (.clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n));
  dcfifo_sync #(.W(1)) u_rd_rst (.clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n));
  dcfifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));
  dcfifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));

  dcfifo_wr_ctl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW), .PW(PW), .OFF_W(OFF_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .raw_rst_n(rst_n), .wen_n(wen_n), .shr_n(wen2_ld_n),
    .din(din), .rgray_s(rgray_s), .w_fire(w_fire), .waddr(waddr), .wgray(wgray),
    .ae_off(ae_off), .full_n(full_n), .af_n(af_n));

  dcfifo_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .OFF_W(OFF_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .ren_n(ren_n), .ren2_n(ren2_n), .wgray_s(wgray_s),
    .ae_off(ae_off), .r_fire(r_fire), .raddr(raddr), .rgray(rgray),
    .empty_n(empty_n), .ae_n(ae_n));

  dcfifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(w_fire), .waddr(waddr), .wdata(din),
    .rclk(rd_clk), .rrst_n(rd_rst_n), .re(r_fire), .raddr(raddr), .q(q));

  assign q_oe = !oe_n;

  always_comb begin
    assert_oe_qual_R10: assert (q_oe == !oe_n);
  end
endmodule

// File: tb/tb_dcfifo_pf.sv
module tb_dcfifo_pf;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 64;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wen_n = 1, wen2_ld_n = 1, ren_n = 1, ren2_n = 1, oe_n = 1;
  logic [8:0] din = '0;
  logic [8:0] q;
  logic q_oe, empty_n, full_n, ae_n, af_n;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [8:0] mq[$];
  logic [8:0] last_q;
  int mae, maf;
  bit load_mode;
  int seed_v = 9'h0a5;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dcfifo_pf #(.DEPTH(DEPTH), .DATA_W(9)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wen_n(wen_n), .wen2_ld_n(wen2_ld_n),
    .din(din), .ren_n(ren_n), .ren2_n(ren2_n), .oe_n(oe_n), .q(q), .q_oe(q_oe),
    .empty_n(empty_n), .full_n(full_n), .ae_n(ae_n), .af_n(af_n));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle_chk(string req);
    int cnt;
    repeat (10) @(negedge wr_clk);
    repeat (10) @(negedge rd_clk);
    cnt = mq.size();
    check({req, " empty_n"}, empty_n, cnt != 0);
    check({req, " full_n"},  full_n,  cnt != DEPTH);
    check({req, " ae_n"},    ae_n,    !(cnt <= mae));
    check({req, " af_n"},    af_n,    !((DEPTH - cnt) <= maf));
  endtask

  task automatic do_reset(bit pin);
    rst_n = 0; wen_n = 1; ren_n = 1; ren2_n = 1; wen2_ld_n = pin;
    repeat (3) @(negedge wr_clk);
    rst_n = 1;
    repeat (6) @(negedge wr_clk);
    wen2_ld_n = 1;
    mq.delete(); last_q = '0; mae = 7; maf = 7; load_mode = !pin;
  endtask

  // one write attempt; sec = level driven on wen2_ld_n
  task automatic do_wr(logic [8:0] d, bit sec);
    bit f;
    @(negedge wr_clk);
    f = full_n;
    if (f) begin
      total++;
      if (mq.size() >= DEPTH) begin bad++; $display("FAIL R3 full_n=1 with %0d words, expected full", mq.size()); end
    end
    wen_n = 0; wen2_ld_n = sec; din = d;
    @(negedge wr_clk);
    wen_n = 1; wen2_ld_n = 1;
    if (f && (load_mode ? sec : !sec)) mq.push_back(d);
  endtask

  task automatic do_rd(bit both);
    bit e;
    @(negedge rd_clk);
    e = empty_n;
    ren_n = 0; ren2_n = !both;
    @(negedge rd_clk);
    ren_n = 1; ren2_n = 1;
    if (both && e) begin
      if (mq.size() == 0) begin
        total++; bad++; $display("FAIL R4 read granted on empty model, actual=1 expected=0");
      end else last_q = mq.pop_front();
    end
    check(both ? "R2 read data" : "R2 single enable keeps q", q, last_q);
  endtask

  task automatic wr_n(int n);
    for (int i = 0; i < n; i++) begin
      seed_v = (seed_v * 37 + 11) % 512;
      do_wr(9'(seed_v), 1'b0 ^ load_mode);
    end
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    settle_chk("R9");
    check("R9 q", q, 0);
    // R1: only one write enable low
    for (int i = 0; i < 3; i++) begin
      @(negedge wr_clk); wen_n = 0; wen2_ld_n = 1; din = 9'h55;
      @(negedge wr_clk); wen_n = 1;
    end
    settle_chk("R1 single enable");
    @(negedge wr_clk); wen_n = 1; wen2_ld_n = 0; din = 9'h66;
    @(negedge wr_clk); wen2_ld_n = 1;
    settle_chk("R1 other enable");
    // R1/R5: eight words then boundary at seven
    wr_n(8);
    settle_chk("R5 count8");
    do_rd(1'b1);
    settle_chk("R5 count7");
    do_rd(1'b0);
    settle_chk("R2 single read enable");
    // R10
    oe_n = 1; #1 check("R10 oe high", q_oe, 0);
    oe_n = 0; #1 check("R10 oe low", q_oe, 1);
    for (int i = 0; i < 7; i++) do_rd(1'b1);
    settle_chk("R4 drained");
    // R6/R3 fill
    wr_n(56);
    settle_chk("R6 free8");
    wr_n(1);
    settle_chk("R6 free7");
    wr_n(7);
    settle_chk("R3 full");
    do_wr(9'h1ff, 1'b0);
    settle_chk("R3 write on full");
    for (int i = 0; i < DEPTH; i++) do_rd(1'b1);
    settle_chk("R4 empty again");
    do_rd(1'b1);
    check("R4 read on empty q", q, last_q);
    // R7/R8: load mode
    do_reset(1'b0);
    settle_chk("R7 load mode reset");
    @(negedge wr_clk); wen_n = 0; wen2_ld_n = 0; din = 9'd3;
    @(negedge wr_clk); din = 9'd5;
    @(negedge wr_clk); wen_n = 1; wen2_ld_n = 1;
    mae = 3; maf = 5;
    settle_chk("R8 loads push nothing");
    wr_n(3);
    settle_chk("R8 ae offset 3 at count3");
    wr_n(1);
    settle_chk("R8 ae offset 3 at count4");
    begin
      logic [8:0] first_w;
      first_w = mq[0];
      do_rd(1'b1);
      check("R8 first data word", last_q, first_w);
    end
    wr_n(55);
    settle_chk("R8 af offset 5 free6");
    wr_n(1);
    settle_chk("R8 af offset 5 free5");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule